// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the power modes of a small microcontroller subsystem. Software requests a CPU idle state and a supply-converter mode (normal, standby or off) through a control write. From its current modes the block drives one enable per functional domain: CPU, RAM, general timers, serial ports, interrupt logic, real-time clock and protocol timer. It also drives a RAM retention flag, the converter mode code and a status word that software can read.

CPU idle and converter mode are two independent axes. Idle stops only the CPU and ends on the next cycle after any enabled interrupt. A converter change needs a settling window of `SETTLE_CYCLES` cycles before the new mode takes effect. A request written during that window is held and issued once the window closes. In converter off mode only the real-time clock, the protocol timer and RAM retention stay alive. That mode ends only on a clock or protocol-timer event, or on reset.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset (active-low `rst_n`, asynchronous) the converter is in normal mode (code 00), the CPU runs, every domain enable is 1, `ram_retain` is 0, `conv_busy` is 0 and `status` is 0.
- R2: A control write is `wr_en` with `wr_idle` (1 requests idle) and `wr_conv` (00 normal, 01 standby, 10 off, 11 keep the current mode). The write is taken only while `en_cpu` is 1; otherwise it has no effect.
- R3: A write taken with `wr_idle`=1 while no transition is in progress, with no held request and no interrupt, drives `en_cpu` to 0 after that edge. RAM, timer, serial, interrupt, clock and protocol-timer enables stay 1.
- R4: `irq` high at an edge clears idle, so `en_cpu` is 1 after that edge. This also applies when an idle write is taken at the same edge.
- R5: A write that selects a converter code other than 11 and other than the current one raises `conv_busy` for exactly `SETTLE_CYCLES` cycles. `conv_mode` changes to the new code at the edge where `conv_busy` falls.
- R6: In converter off mode `en_cpu`, `en_ram`, `en_timer`, `en_serial` and `en_intc` are 0, while `ram_retain`, `en_rtc` and `en_ptmr` are 1. Idle is cleared on entry.
- R7: Off mode ignores `irq` and control writes. `rtc_evt` or `ptmr_evt` at an edge while settled in off mode starts a transition to normal mode.
- R8: A write taken while `conv_busy` is 1 is held, and a later write replaces it. It is applied at the first edge after `conv_busy` falls. A held request is dropped when the converter reaches off mode.
- R9: `status[1:0]` gives the CPU mode (00 running, 01 idle, 10 halted by converter off). `status[3:2]` gives the settled converter code.
- R10: In standby mode every domain enable matches normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_idle | input | 1 | Idle request bit of the write |
| wr_conv | input | 2 | Converter mode code of the write |
| irq | input | 1 | Any enabled interrupt pending |
| rtc_evt | input | 1 | Real-time clock wake event |
| ptmr_evt | input | 1 | Protocol timer wake event |
| en_cpu | output | 1 | CPU enable |
| en_ram | output | 1 | RAM access enable |
| ram_retain | output | 1 | RAM retention flag |
| en_timer | output | 1 | General timer enable |
| en_serial | output | 1 | Serial port enable |
| en_intc | output | 1 | Interrupt logic enable |
| en_rtc | output | 1 | Real-time clock enable |
| en_ptmr | output | 1 | Protocol timer enable |
| conv_mode | output | 2 | Settled converter mode code |
| conv_busy | output | 1 | Converter transition in progress |
| status | output | 4 | Software status word |

## Verification
Two functions can land on the same edge. An idle request can arrive together with an interrupt. A write can arrive in the cycle where a settling window closes or a held request is issued. The bench forces the first case by driving `irq` and an idle write together, and expects the CPU to stay enabled. The second case is forced by writing during `conv_busy` and in its last cycle, where the held-request and drop-on-off rules decide the outcome. A bench reference model, compared against every output on every cycle, judges both cases under random stimulus as well.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [1:0] {
    CONV_NORMAL  = 2'b00,
    CONV_STANDBY = 2'b01,
    CONV_OFF     = 2'b10,
    CONV_KEEP    = 2'b11
  } conv_t;

  typedef struct packed {
    logic cpu;
    logic ram;
    logic retain;
    logic timer;
    logic serial;
    logic intc;
    logic rtc;
    logic ptmr;
  } dom_en_t;

  // CPU mode field of the status word
  function automatic logic [1:0] cpu_field(input logic idle, input conv_t conv);
    if (conv == CONV_OFF) return 2'b10;
    if (idle)             return 2'b01;
    return 2'b00;
  endfunction

  // A request changes the converter only for a real, different code
  function automatic logic wants_change(input conv_t req, input conv_t cur);
    return (req != CONV_KEEP) && (req != cur);
  endfunction

  function automatic dom_en_t domain_mask(input logic idle, input conv_t conv);
    dom_en_t m;
    m.rtc  = 1'b1;
    m.ptmr = 1'b1;
    if (conv == CONV_OFF) begin
      m.cpu = 1'b0; m.ram = 1'b0; m.retain = 1'b1;
      m.timer = 1'b0; m.serial = 1'b0; m.intc = 1'b0;
    end else begin
      m.cpu = !idle; m.ram = 1'b1; m.retain = 1'b0;
      m.timer = 1'b1; m.serial = 1'b1; m.intc = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pwr_req_hold.sv
module pwr_req_hold
  import pwr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  clear,
  input  logic  in_idle,
  input  conv_t in_conv,
  output logic  valid,
  output logic  held_idle,
  output conv_t held_conv
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      held_idle <= 1'b0;
      held_conv <= CONV_KEEP;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid     <= 1'b1;
      held_idle <= in_idle;
      held_conv <= in_conv;
    end
  end

endmodule

// File: rtl/pwr_mode_core.sv
module pwr_mode_core
  import pwr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_acc,
  input  logic  wr_idle,
  input  conv_t wr_conv,
  input  logic  pend_valid,
  input  logic  pend_idle,
  input  conv_t pend_conv,
  input  logic  irq,
  input  logic  rtc_evt,
  input  logic  ptmr_evt,
  output conv_t conv_cur,
  output logic  idle_q,
  output logic  busy_q,
  output logic  pend_load,
  output logic  pend_clear
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  conv_t           conv_tgt;
  logic [CNT_W-1:0] cnt_q;
  logic            idle_n;

  // named internal events
  logic settle_done, in_off, wake_evt, src_valid, src_idle;
  logic start_req, start_wake, enter_off;
  conv_t src_conv;

  assign settle_done = busy_q && (cnt_q == '0);
  assign in_off      = (conv_cur == CONV_OFF);
  assign wake_evt    = rtc_evt || ptmr_evt;
  assign src_valid   = pend_valid || wr_acc;
  assign src_idle    = pend_valid ? pend_idle : wr_idle;
  assign src_conv    = pend_valid ? pend_conv : wr_conv;
  assign start_req   = !busy_q && !in_off && src_valid && wants_change(src_conv, conv_cur);
  assign start_wake  = !busy_q && in_off && wake_evt;
  assign enter_off   = settle_done && (conv_tgt == CONV_OFF);

  assign pend_load  = wr_acc && (busy_q || pend_valid);
  assign pend_clear = enter_off || (!busy_q && in_off) ||
                      (!busy_q && !in_off && pend_valid && !wr_acc);

  always_comb begin
    idle_n = idle_q;
    if (!busy_q && !in_off && src_valid) idle_n = src_idle;
    if (irq)                             idle_n = 1'b0;
    if (enter_off || in_off)             idle_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_cur <= CONV_NORMAL;
      conv_tgt <= CONV_NORMAL;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      idle_q   <= 1'b0;
    end else begin
      idle_q <= idle_n;
      if (busy_q) begin
        if (cnt_q == '0) begin
          conv_cur <= conv_tgt;
          busy_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_wake) begin
        conv_tgt <= CONV_NORMAL;
        cnt_q    <= CNT_LOAD;
        busy_q   <= 1'b1;
      end else if (start_req) begin
        conv_tgt <= src_conv;
        cnt_q    <= CNT_LOAD;
        busy_q   <= 1'b1;
      end
    end
  end

  assert_irq_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !idle_q);

  assert_idle_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !in_off && wr_acc && wr_idle && !pend_valid && !irq) |=> idle_q);

  assert_conv_only_on_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(conv_cur));

  assert_off_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_off && !busy_q && !wake_evt) |=> (conv_cur == CONV_OFF) && !busy_q);

  assert_hold_on_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_acc && !enter_off) |=> pend_valid);

endmodule

// File: rtl/pwr_domain_dec.sv
module pwr_domain_dec
  import pwr_pkg::*;
(
  input  logic       idle,
  input  conv_t      conv,
  output dom_en_t    en,
  output logic [3:0] status
);

  assign en     = domain_mask(idle, conv);
  assign status = {conv, cpu_field(idle, conv)};

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_idle,
  input  logic [1:0] wr_conv,
  input  logic       irq,
  input  logic       rtc_evt,
  input  logic       ptmr_evt,
  output logic       en_cpu,
  output logic       en_ram,
  output logic       ram_retain,
  output logic       en_timer,
  output logic       en_serial,
  output logic       en_intc,
  output logic       en_rtc,
  output logic       en_ptmr,
  output logic [1:0] conv_mode,
  output logic       conv_busy,
  output logic [3:0] status
);

  conv_t   conv_cur, pend_conv;
  logic    idle_q, busy_q, pend_load, pend_clear, pend_valid, pend_idle;
  logic    wr_acc;
  dom_en_t en;

  // software can write only while the CPU is clocked
  assign wr_acc = wr_en && en.cpu;

  pwr_req_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pend_load),
    .clear     (pend_clear),
    .in_idle   (wr_idle),
    .in_conv   (conv_t'(wr_conv)),
    .valid     (pend_valid),
    .held_idle (pend_idle),
    .held_conv (pend_conv)
  );

  pwr_mode_core #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_acc     (wr_acc),
    .wr_idle    (wr_idle),
    .wr_conv    (conv_t'(wr_conv)),
    .pend_valid (pend_valid),
    .pend_idle  (pend_idle),
    .pend_conv  (pend_conv),
    .irq        (irq),
    .rtc_evt    (rtc_evt),
    .ptmr_evt   (ptmr_evt),
    .conv_cur   (conv_cur),
    .idle_q     (idle_q),
    .busy_q     (busy_q),
    .pend_load  (pend_load),
    .pend_clear (pend_clear)
  );

  pwr_domain_dec u_dec (
    .idle   (idle_q),
    .conv   (conv_cur),
    .en     (en),
    .status (status)
  );

  assign en_cpu     = en.cpu;
  assign en_ram     = en.ram;
  assign ram_retain = en.retain;
  assign en_timer   = en.timer;
  assign en_serial  = en.serial;
  assign en_intc    = en.intc;
  assign en_rtc     = en.rtc;
  assign en_ptmr    = en.ptmr;
  assign conv_mode  = conv_cur;
  assign conv_busy  = busy_q;

  assert_off_entry_domains_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(conv_busy) && conv_mode == 2'b10) |->
      (ram_retain && en_rtc && en_ptmr && !en_cpu && !en_serial && !en_timer && !en_ram));

  assert_no_write_when_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_cpu && !conv_busy && !pend_valid) |=> !conv_busy || (conv_mode == 2'b10));

endmodule

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
module tb_pwr_mode_seq;

  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_idle = 0, irq = 0, rtc_evt = 0, ptmr_evt = 0;
  logic [1:0] wr_conv = 2'b11;
  logic en_cpu, en_ram, ram_retain, en_timer, en_serial, en_intc, en_rtc, en_ptmr;
  logic [1:0] conv_mode;
  logic conv_busy;
  logic [3:0] status;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pwr_mode_seq #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idle(wr_idle), .wr_conv(wr_conv),
    .irq(irq), .rtc_evt(rtc_evt), .ptmr_evt(ptmr_evt),
    .en_cpu(en_cpu), .en_ram(en_ram), .ram_retain(ram_retain), .en_timer(en_timer),
    .en_serial(en_serial), .en_intc(en_intc), .en_rtc(en_rtc), .en_ptmr(en_ptmr),
    .conv_mode(conv_mode), .conv_busy(conv_busy), .status(status)
  );

  // reference model state
  logic [1:0] m_conv = 0, m_tgt = 0, m_pconv = 0;
  logic m_idle = 0, m_busy = 0, m_pv = 0, m_pidle = 0;
  int   m_left = 0;

  function automatic bit m_cpu_on();
    return (m_conv != 2'b10) && !m_idle;
  endfunction

  function automatic logic [3:0] m_status();
    logic [1:0] c;
    c = (m_conv == 2'b10) ? 2'b10 : {1'b0, m_idle};
    return {m_conv, c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_conv = 0; m_tgt = 0; m_idle = 0; m_busy = 0; m_pv = 0; m_left = 0;
    end else begin
      bit take, have, r_idle;
      logic [1:0] r_conv;
      take = wr_en && m_cpu_on();
      if (m_busy) begin
        if (take) begin m_pv = 1; m_pidle = wr_idle; m_pconv = wr_conv; end
        if (irq) m_idle = 0;
        if (m_left == 0) begin
          m_busy = 0; m_conv = m_tgt;
          if (m_tgt == 2'b10) begin m_idle = 0; m_pv = 0; end
        end else m_left--;
      end else if (m_conv == 2'b10) begin
        m_pv = 0; m_idle = 0;
        if (rtc_evt || ptmr_evt) begin m_busy = 1; m_tgt = 2'b00; m_left = SETTLE - 1; end
      end else begin
        have = m_pv || take;
        r_idle = m_pv ? m_pidle : wr_idle;
        r_conv = m_pv ? m_pconv : wr_conv;
        if (m_pv) begin
          if (take) begin m_pidle = wr_idle; m_pconv = wr_conv; end
          else m_pv = 0;
        end
        if (have) begin
          m_idle = r_idle;
          if (r_conv != 2'b11 && r_conv != m_conv) begin
            m_busy = 1; m_tgt = r_conv; m_left = SETTLE - 1;
          end
        end
        if (irq) m_idle = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_model();
    bit off;
    off = (m_conv == 2'b10);
    chk("R3 en_cpu", en_cpu, m_cpu_on());
    chk("R6 en_ram", en_ram, !off);
    chk("R6 ram_retain", ram_retain, off);
    chk("R10 en_timer", en_timer, !off);
    chk("R10 en_serial", en_serial, !off);
    chk("R10 en_intc", en_intc, !off);
    chk("R6 en_rtc", en_rtc, 1);
    chk("R6 en_ptmr", en_ptmr, 1);
    chk("R5 conv_mode", conv_mode, m_conv);
    chk("R5 conv_busy", conv_busy, m_busy);
    chk("R9 status", status, m_status());
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_model();
  endtask

  task automatic write(input bit idle, input logic [1:0] conv);
    wr_en = 1; wr_idle = idle; wr_conv = conv;
    tick();
    wr_en = 0;
  endtask

  task automatic wait_settle();
    for (int i = 0; i < 50 && conv_busy; i++) tick();
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h1A2B3C));
    @(negedge clk); @(negedge clk);
    chk("R1 status in reset", status, 0);
    chk("R1 en_cpu in reset", en_cpu, 1);
    chk("R1 busy in reset", conv_busy, 0);
    rst_n = 1;
    tick();
    // R3 idle entry
    write(1, 2'b11);
    chk("R3 cpu off in idle", en_cpu, 0);
    chk("R3 serial kept", en_serial, 1);
    chk("R9 idle field", status, 4'b0001);
    // R2 write ignored while idle
    write(0, 2'b01);
    chk("R2 write ignored when halted", conv_busy, 0);
    // R4 wake
    irq = 1; tick(); irq = 0;
    chk("R4 irq wakes", en_cpu, 1);
    // R4 collision
    irq = 1; write(1, 2'b11); irq = 0;
    chk("R4 irq beats idle write", en_cpu, 1);
    // R5 standby transition length
    write(0, 2'b01);
    n = 0;
    while (conv_busy && n < 50) begin n++; tick(); end
    chk("R5 settle length", n, SETTLE);
    chk("R10 standby mode", conv_mode, 2'b01);
    chk("R10 standby serial on", en_serial, 1);
    // R8 held request
    write(0, 2'b00);
    write(1, 2'b10);
    wait_settle();
    chk("R8 first target reached", conv_mode, 2'b00);
    tick();
    chk("R8 held request started", conv_busy, 1);
    chk("R8 held idle applied", en_cpu, 0);
    wait_settle();
    chk("R6 off mode", conv_mode, 2'b10);
    chk("R6 retain", ram_retain, 1);
    chk("R6 cpu off", en_cpu, 0);
    chk("R9 halted status", status, 4'b1010);
    // R7 irq and writes ignored in off
    irq = 1; wr_en = 1; wr_conv = 2'b00;
    for (int i = 0; i < 5; i++) tick();
    irq = 0; wr_en = 0;
    chk("R7 off held", conv_mode, 2'b10);
    chk("R7 no transition", conv_busy, 0);
    rtc_evt = 1; tick(); rtc_evt = 0;
    chk("R7 rtc starts exit", conv_busy, 1);
    wait_settle();
    chk("R7 back to normal", conv_mode, 2'b00);
    chk("R7 cpu running", en_cpu, 1);
    // R7 ptmr exit, with write in the closing cycle (R8 drop)
    write(0, 2'b10);
    for (int i = 0; i < SETTLE - 1; i++) tick();
    write(0, 2'b01);
    chk("R8 held request dropped at off", conv_mode, 2'b10);
    tick();
    chk("R8 no restart from off", conv_busy, 0);
    ptmr_evt = 1; tick(); ptmr_evt = 0;
    wait_settle();
    chk("R7 ptmr exit", conv_mode, 2'b00);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      wr_en    = ($urandom % 6) == 0;
      wr_idle  = ($urandom % 3) == 0;
      wr_conv  = 2'($urandom % 4);
      irq      = ($urandom % 9) == 0;
      rtc_evt  = ($urandom % 40) == 0;
      ptmr_evt = ($urandom % 55) == 0;
      tick();
    end
    wr_en = 0; irq = 0; rtc_evt = 0; ptmr_evt = 0;
    // R1 reset mid-run
    rst_n = 0; #1;
    chk("R1 async reset status", status, 0);
    chk("R1 async reset busy", conv_busy, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule